// File: doc/BRIEF.md
# Modulo Alarm Timer

This block is a 16-bit up-counter behind a small 32-bit register bus that raises an alarm. Two external single-cycle tick enables feed it: a system tick and a fixed-frequency tick. Both are in the system clock domain. A control field picks one of the two ticks or stops the timer. A power-of-two prescaler divides the chosen tick. Each prescaled tick advances the count.

The count climbs from a programmable start value to a programmable modulo value. On the next tick after the count equals the modulo value, the count reloads the start value. That reload sets a sticky overflow flag. Software can only restart the count, and it does so by writing the count register. The interrupt output follows the overflow flag when interrupts are enabled.

Software clears the flag with a read-then-write-zero sequence. The sequence is held by an overflow state machine with three states:
- **OVF_IDLE**: the flag is clear.
- **OVF_PENDING**: the flag is set and has not yet been read.
- **OVF_SEEN**: the flag is set and has been read as 1.

Its transitions are:
- **wrap**: any state goes to OVF_PENDING on an overflow event.
- **observe**: OVF_PENDING goes to OVF_SEEN on a read of the control register.
- **acknowledge**: OVF_SEEN goes to OVF_IDLE on a control write with the flag bit at 0.
- **hold**: every other case stays in the current state.

Top module: `modtimer_alarm`

## Requirements
- R1: After reset the count, start value and control register read 0, the modulo register reads 0x0000FFFF, and irq is low.
- R2: Each prescaled tick increments the count by one. When a prescaled tick arrives while the count equals the modulo value, the count loads the start value instead.
- R3: The overflow flag (control bit 7) is set only by the modulo-to-start reload. Reaching the modulo value does not set it.
- R4: A write of any data to the count register (offset 0x04) loads the start value into the count one cycle later. That write takes priority over a tick in the same cycle and produces no overflow.
- R5: The count, modulo and start registers hold 16 bits. Their bits 31:16 read 0 and ignore writes. A read of any unmapped offset, or the bus data when no read is in progress, is 0.
- R6: The prescale field (control bits 2:0, value n) passes one tick in every 2^n selected ticks. A source value of 0 or 3 resets the divider, so after a restart the first count step comes on the 2^n-th tick.
- R7: The source field (control bits 4:3) selects the count source. Value 1 selects tick_sys, value 2 selects tick_fixed, and values 0 and 3 stop the count. The unselected tick has no effect.
- R8: irq is high exactly while the interrupt enable (control bit 6) is 1 and the overflow flag is set.
- R9: The flag clears only when a control write with bit 7 at 0 follows a control read that returned the flag as 1. Writing 1 to bit 7, or writing 0 without that read, leaves the flag set.
- R10: If an overflow event and a clearing write fall in the same cycle, the flag stays set. A new read is then needed before a write of 0 can clear it.
- R11: The register offsets are: control at 0x00, count at 0x04, modulo at 0x08, start value at 0x4C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| tick_sys | input | 1 | Single-cycle system tick enable |
| tick_fixed | input | 1 | Single-cycle fixed-frequency tick enable |
| irq | output | 1 | Alarm interrupt |

## Verification
Two events can fall in the same cycle: a prescaled tick that wraps the count from the modulo value, and the software write of 0 that should clear the overflow flag. The bench provokes this directly. It first reads the flag as set, then steps the count up to the modulo value, and then issues the clearing write in the same cycle as a tick. The flag must survive, and a further write without a fresh read must not clear it. The same collision, and also a count write colliding with a tick, arise repeatedly in a long random run. In that run every cycle's read data and irq are compared against a cycle-accurate bench model.

// File: rtl/modtimer_pkg.sv
package modtimer_pkg;

    localparam int REG_W = 32;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_CNT  = 8'h04;
    localparam logic [7:0] OFS_MOD  = 8'h08;
    localparam logic [7:0] OFS_INIT = 8'h4C;

    typedef enum logic [1:0] {
        SRC_STOP  = 2'd0,
        SRC_SYS   = 2'd1,
        SRC_FIXED = 2'd2,
        SRC_HALT  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        OVF_IDLE    = 2'd0,
        OVF_PENDING = 2'd1,
        OVF_SEEN    = 2'd2
    } ovf_state_e;

endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler
    import modtimer_pkg::*;
#(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  src_e             src,
    input  logic [PSC_W-1:0] psc,
    input  logic             tick_sys,
    input  logic             tick_fixed,
    output logic             pulse
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] limit;
    logic             sel_tick;
    logic             running;

    always_comb begin
        sel_tick = 1'b0;
        running  = 1'b0;
        unique case (src)
            SRC_SYS: begin
                sel_tick = tick_sys;
                running  = 1'b1;
            end
            SRC_FIXED: begin
                sel_tick = tick_fixed;
                running  = 1'b1;
            end
            SRC_STOP, SRC_HALT: begin
                sel_tick = 1'b0;
                running  = 1'b0;
            end
        endcase
    end

    always_comb begin
        span  = {{DIV_W{1'b0}}, 1'b1} << psc;
        limit = DIV_W'(span - 1'b1);
        pulse = sel_tick && (div_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            div_q <= '0;
        end else if (sel_tick) begin
            div_q <= pulse ? '0 : div_q + 1'b1;
        end
    end

endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] init_val,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_evt
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt      = cnt_q;
    assign wrap_evt = step && !load && (cnt_q == mod_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= init_val;
        end else if (step) begin
            cnt_q <= wrap_evt ? init_val : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mt_ovf_fsm.sv
module mt_ovf_fsm
    import modtimer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic rd_status,
    input  logic wr_status,
    input  logic wr_flag_bit,
    output logic flag
);
    ovf_state_e state_q;
    ovf_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (set_evt) begin
            state_d = OVF_PENDING;
        end else begin
            unique case (state_q)
                OVF_IDLE:    state_d = OVF_IDLE;
                OVF_PENDING: if (rd_status) state_d = OVF_SEEN;
                OVF_SEEN:    if (wr_status && !wr_flag_bit) state_d = OVF_IDLE;
                default:     state_d = OVF_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OVF_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            OVF_PENDING, OVF_SEEN: flag = 1'b1;
            default:               flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/modtimer_alarm.sv
module modtimer_alarm
    import modtimer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_sys,
    input  logic              tick_fixed,
    output logic              irq
);
    localparam int SRC_LSB  = PSC_W;
    localparam int IE_BIT   = PSC_W + 3;
    localparam int FLAG_BIT = PSC_W + 4;

    logic [PSC_W-1:0] psc_q;
    src_e             src_q;
    logic             ie_q;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] cnt_val;
    logic             ovf_flag;
    logic             wrap_evt;
    logic             pre_pulse;

    logic rd_en, wr_en;
    logic hit_ctrl, hit_cnt, hit_mod, hit_init;
    logic [31:0] ctrl_word;

    assign rd_en    = bus_sel && !bus_wr;
    assign wr_en    = bus_sel && bus_wr;
    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_cnt  = (bus_addr == ADDR_W'(OFS_CNT));
    assign hit_mod  = (bus_addr == ADDR_W'(OFS_MOD));
    assign hit_init = (bus_addr == ADDR_W'(OFS_INIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_q  <= '0;
            src_q  <= SRC_STOP;
            ie_q   <= 1'b0;
            mod_q  <= '1;
            init_q <= '0;
        end else if (wr_en) begin
            if (hit_ctrl) begin
                psc_q <= bus_wdata[PSC_W-1:0];
                src_q <= src_e'(bus_wdata[SRC_LSB+1:SRC_LSB]);
                ie_q  <= bus_wdata[IE_BIT];
            end
            if (hit_mod)  mod_q  <= bus_wdata[CNT_W-1:0];
            if (hit_init) init_q <= bus_wdata[CNT_W-1:0];
        end
    end

    mt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk        (clk),
        .rst        (rst),
        .src        (src_q),
        .psc        (psc_q),
        .tick_sys   (tick_sys),
        .tick_fixed (tick_fixed),
        .pulse      (pre_pulse)
    );

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_en && hit_cnt),
        .step     (pre_pulse),
        .init_val (init_q),
        .mod_val  (mod_q),
        .cnt      (cnt_val),
        .wrap_evt (wrap_evt)
    );

    mt_ovf_fsm u_ovf (
        .clk         (clk),
        .rst         (rst),
        .set_evt     (wrap_evt),
        .rd_status   (rd_en && hit_ctrl),
        .wr_status   (wr_en && hit_ctrl),
        .wr_flag_bit (bus_wdata[FLAG_BIT]),
        .flag        (ovf_flag)
    );

    always_comb begin
        ctrl_word                       = '0;
        ctrl_word[PSC_W-1:0]            = psc_q;
        ctrl_word[SRC_LSB+1:SRC_LSB]    = src_q;
        ctrl_word[IE_BIT]               = ie_q;
        ctrl_word[FLAG_BIT]             = ovf_flag;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (hit_ctrl)      bus_rdata = ctrl_word;
            else if (hit_cnt)  bus_rdata = 32'(cnt_val);
            else if (hit_mod)  bus_rdata = 32'(mod_q);
            else if (hit_init) bus_rdata = 32'(init_q);
        end
    end

    assign irq = ie_q && ovf_flag;

endmodule

// File: rtl/modtimer_alarm_chk.sv
module modtimer_alarm_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  mod_q,
    input logic [CNT_W-1:0]  init_q,
    input logic [1:0]        src_q,
    input logic              ovf_flag,
    input logic              wrap_evt
);
    logic cnt_wr, ctrl_wr, data_rd;
    assign cnt_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(8'h04));
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(8'h00));
    assign data_rd = bus_sel && !bus_wr &&
                     ((bus_addr == ADDR_W'(8'h04)) || (bus_addr == ADDR_W'(8'h08)) ||
                      (bus_addr == ADDR_W'(8'h4C)));

    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt_val == $past(init_q))); // R4

    AST_FLAG_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> ($past(cnt_val) == $past(mod_q) && cnt_val == $past(init_q))); // R3

    AST_W1_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && ctrl_wr && bus_wdata[7]) |=> ovf_flag); // R9

    AST_WRAP_WINS: assert property (@(posedge clk) disable iff (rst)
        wrap_evt |=> ovf_flag); // R10

    AST_STOPPED: assert property (@(posedge clk) disable iff (rst)
        ((src_q == 2'd0 || src_q == 2'd3) && !cnt_wr) |=> $stable(cnt_val)); // R7

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        data_rd |-> (bus_rdata[31:16] == 16'h0)); // R5

endmodule

bind modtimer_alarm modtimer_alarm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_val   (cnt_val),
    .mod_q     (mod_q),
    .init_q    (init_q),
    .src_q     (src_q),
    .ovf_flag  (ovf_flag),
    .wrap_evt  (wrap_evt)
);

// File: tb/modtimer_alarm_tb.sv
module modtimer_alarm_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        b_sel = 1'b0, b_wr = 1'b0;
    logic [7:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic        t_sys = 1'b0, t_fix = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    modtimer_alarm u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (b_sel),
        .bus_wr     (b_wr),
        .bus_addr   (b_addr),
        .bus_wdata  (b_wdata),
        .bus_rdata  (b_rdata),
        .tick_sys   (t_sys),
        .tick_fixed (t_fix),
        .irq        (irq)
    );

    // reference model state
    logic [2:0]  m_psc;
    logic [1:0]  m_src;
    logic        m_ie;
    int          m_st;      // 0 clear, 1 set unread, 2 set and read
    logic [15:0] m_cnt, m_mod, m_init;
    logic [6:0]  m_div;
    logic [31:0] last_rd;
    logic        last_irq;

    task automatic model_reset();
        m_psc = 0; m_src = 0; m_ie = 0; m_st = 0;
        m_cnt = 0; m_mod = 16'hFFFF; m_init = 0; m_div = 0;
    endtask

    function automatic logic [31:0] exp_rdata();
        if (!(b_sel && !b_wr)) return 32'h0;
        case (b_addr)
            8'h00:   return {24'h0, (m_st != 0), m_ie, 1'b0, m_src, m_psc};
            8'h04:   return {16'h0, m_cnt};
            8'h08:   return {16'h0, m_mod};
            8'h4C:   return {16'h0, m_init};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag();
        if (!(b_sel && !b_wr)) return "R5";
        case (b_addr)
            8'h00:        return "R9";
            8'h04:        return "R2";
            8'h08, 8'h4C: return "R11";
            default:      return "R5";
        endcase
    endfunction

    task automatic model_update();
        logic tk, pt, evt, wr_c, rd_c;
        logic [6:0] lim;
        rd_c = b_sel && !b_wr && b_addr == 8'h00;
        wr_c = b_sel && b_wr && b_addr == 8'h00;
        tk  = (m_src == 2'd1) ? t_sys : (m_src == 2'd2) ? t_fix : 1'b0;
        lim = 7'((8'd1 << m_psc) - 8'd1);
        pt  = tk && (m_div >= lim);
        evt = 0;
        if (m_src == 2'd0 || m_src == 2'd3) m_div = 0;
        else if (tk) m_div = pt ? 7'd0 : m_div + 7'd1;
        if (b_sel && b_wr && b_addr == 8'h04) m_cnt = m_init;
        else if (pt) begin
            if (m_cnt == m_mod) begin m_cnt = m_init; evt = 1; end
            else m_cnt = m_cnt + 16'd1;
        end
        if (evt) m_st = 1;
        else if (m_st == 1 && rd_c) m_st = 2;
        else if (m_st == 2 && wr_c && !b_wdata[7]) m_st = 0;
        if (wr_c) begin
            m_psc = b_wdata[2:0]; m_src = b_wdata[4:3]; m_ie = b_wdata[6];
        end
        if (b_sel && b_wr && b_addr == 8'h08) m_mod  = b_wdata[15:0];
        if (b_sel && b_wr && b_addr == 8'h4C) m_init = b_wdata[15:0];
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        #1;
        last_rd  = b_rdata;
        last_irq = irq;
        check(rd_tag(), b_rdata, exp_rdata());
        check("R8", {31'h0, irq}, {31'h0, m_ie && (m_st != 0)});
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic ts, input logic tf);
        for (int i = 0; i < n; i++) begin
            b_sel = 0; b_wr = 0; t_sys = ts; t_fix = tf;
            step();
        end
        t_sys = 0; t_fix = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic ts);
        b_sel = 1; b_wr = 1; b_addr = a; b_wdata = d; t_sys = ts; t_fix = 0;
        step();
        b_sel = 0; b_wr = 0; t_sys = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        b_sel = 1; b_wr = 0; b_addr = a; t_sys = 0; t_fix = 0;
        step();
        d = last_rd;
        b_sel = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset values
        rd(8'h00, v); check("R1", v, 32'h0);
        check("R1", {31'h0, last_irq}, 32'h0);
        rd(8'h08, v); check("R1", v, 32'h0000FFFF);
        rd(8'h04, v); check("R1", v, 32'h0);

        // R5 / R11 register map and reserved bits
        wr(8'h08, 32'hABCD1234, 0); rd(8'h08, v); check("R5", v, 32'h00001234);
        rd(8'h10, v); check("R5", v, 32'h0);
        wr(8'h4C, 32'hFFFF0003, 0); rd(8'h4C, v); check("R11", v, 32'h00000003);

        // R4 count write loads start value
        wr(8'h04, 32'h00005555, 0); rd(8'h04, v); check("R4", v, 32'h3);

        // R2 / R3 / R8 counting and wrap
        wr(8'h08, 32'd5, 0);
        wr(8'h00, 32'h48, 0);
        idle(2, 1, 0);
        rd(8'h00, v); check("R3", v, 32'h48);
        rd(8'h04, v); check("R2", v, 32'd5);
        idle(1, 1, 0);
        rd(8'h04, v); check("R2", v, 32'd3);
        check("R8", {31'h0, last_irq}, 32'h1);

        // R9 clear protocol
        wr(8'h00, 32'h48, 0);
        rd(8'h00, v); check("R9", v, 32'hC8);
        wr(8'h00, 32'hC8, 0);
        rd(8'h00, v); check("R9", v, 32'hC8);
        wr(8'h00, 32'h48, 0);
        rd(8'h00, v); check("R9", v, 32'h48);
        check("R8", {31'h0, last_irq}, 32'h0);

        // R10 collision of wrap and clear
        idle(3, 1, 0);
        rd(8'h00, v); check("R10", v, 32'hC8);
        idle(2, 1, 0);
        wr(8'h00, 32'h48, 1);
        wr(8'h00, 32'h48, 0);
        rd(8'h00, v); check("R10", v, 32'hC8);
        wr(8'h00, 32'h48, 0);
        rd(8'h00, v); check("R10", v, 32'h48);

        // R6 / R7 prescaler and source select
        wr(8'h00, 32'h12, 0);
        wr(8'h04, 32'h0, 0);
        idle(3, 0, 1); rd(8'h04, v); check("R6", v, 32'd3);
        idle(1, 0, 1); rd(8'h04, v); check("R6", v, 32'd4);
        idle(4, 1, 0); rd(8'h04, v); check("R7", v, 32'd4);
        idle(2, 0, 1);
        wr(8'h00, 32'h00, 0);
        wr(8'h00, 32'h12, 0);
        idle(3, 0, 1); rd(8'h04, v); check("R6", v, 32'd4);
        idle(1, 0, 1); rd(8'h04, v); check("R6", v, 32'd5);
        wr(8'h00, 32'h18, 0);
        idle(5, 1, 1); rd(8'h04, v); check("R7", v, 32'd5);

        // random phase, every cycle compared to the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            t_sys = 1'($urandom_range(0, 1));
            t_fix = 1'($urandom_range(0, 1));
            b_sel = 0; b_wr = 0;
            if (r >= 6) begin
                int ai;
                ai = $urandom_range(0, 5);
                b_sel = 1;
                b_wr  = 1'($urandom_range(0, 1));
                case (ai)
                    0, 1: b_addr = 8'h00;
                    2: b_addr = 8'h04;
                    3: b_addr = 8'h08;
                    4: b_addr = 8'h4C;
                    default: b_addr = 8'h14;
                endcase
                b_wdata = $urandom;
                if (b_addr == 8'h00) b_wdata = {24'h0, 8'($urandom)} | 32'h8;
                if (b_addr == 8'h00 && $urandom_range(0, 1) == 1) b_wdata[2:0] = 3'd0;
                if (b_addr == 8'h08) b_wdata[15:0] = 16'($urandom_range(0, 12));
                if (b_addr == 8'h4C) b_wdata[15:0] = 16'($urandom_range(0, 6));
            end
            step();
        end
        b_sel = 0; t_sys = 0; t_fix = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule